// File: doc/BRIEF.md
# Speculation-Aware Fetch Request Controller

This block drives the request side of an in-order instruction fetch. It holds the fetch address and issues one request at a time to the instruction cache over a valid/ready handshake. Each request carries a speculative bit. That bit is set once an accepted instruction turns out to be a control-flow instruction whose outcome is still open, and it is cleared when the branch resolves. A request whose address lies in a region that must not be read twice (a non-idempotent region) is never issued while the speculative bit is set. The controller holds it back and raises a stall until the speculation resolves.

When the instruction queue cannot take a returned instruction, it signals a replay. The controller then waits for the queue to become ready and fetches the same address again. On the replay it restores the speculative state to the value carried by the rejected request. This undoes the effect of a rejected branch, so the refetch of that branch from a non-idempotent region is never held back by its own speculation and cannot deadlock.

A flush drops all speculative and replay state, discards any response still in flight, and restarts fetching from a supplied address.

Top module: `fetch_spec_ctrl`

## Requirements
- R1: After reset the controller requests address RESET_PC (0x1000 by default) with the speculative bit low and the stall output low.
- R2: A response taken with replay low advances the next request address by INSTR_BYTES (4 by default).
- R3: A taken response flagged as a branch with replay low sets the speculative bit, and the following requests carry it on req_spec_o.
- R4: A request never goes out to a non-idempotent region (region_idem_i low) while the speculative bit is set. Instead req_valid_o is low and stall_o is high.
- R5: Requests to idempotent regions are issued whether or not the speculative bit is set.
- R6: A resolve pulse clears the speculative bit from the next cycle, unless a branch is taken without replay in the same cycle, in which case the bit stays set.
- R7: After a response taken with replay high, no request is made and stall_o stays high until q_ready_i is high. The next request then uses the same address.
- R8: On a replay the speculative bit returns to the value carried by the rejected request, cleared if a resolve has arrived since. A rejected branch fetched non-speculatively from a non-idempotent region is therefore requested again within two cycles of q_ready_i rising.
- R9: While req_valid_o is high and req_ready_i is low, req_addr_o and req_spec_o hold their values into the next cycle unless flush_i or resolve_i is high.
- R10: A flush makes the next request use flush_pc_i with the speculative bit low. A response still outstanding at the flush is discarded and has no effect on the speculative bit or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Redirect fetch and drop speculative and replay state |
| flush_pc_i | input | AW | Restart address used with flush_i |
| region_idem_i | input | 1 | High when the current request address lies in an idempotent region |
| req_valid_o | output | 1 | Cache request valid |
| req_ready_i | input | 1 | Cache accepts the request |
| req_addr_o | output | AW | Cache request address |
| req_spec_o | output | 1 | Speculative bit of the request |
| rsp_valid_i | input | 1 | Cache returns the fetched instruction |
| rsp_branch_i | input | 1 | Returned instruction is an unresolved control-flow instruction |
| resolve_i | input | 1 | Outstanding branch has resolved |
| q_ready_i | input | 1 | Instruction queue has room again |
| replay_i | input | 1 | Queue rejected the returned instruction |
| stall_o | output | 1 | Fetch held by speculation or by a pending replay |

## Verification
On every cycle, the assertions check that no speculative request is presented to a non-idempotent region, that a pending request stays stable, and that flush, resolve, branch and replay each move the speculative bit and the stall as required. Only the bench scenarios can show the sequences: the address sequence against a scoreboard, the rollback to the speculative value of the rejected request rather than to zero, the bounded recovery from a rejected non-idempotent branch, and the dropping of a response that was in flight at a flush.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        ST_REQ   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DRAIN = 2'd3
    } fetch_st_e;

    typedef struct packed {
        logic spec;   // live speculative flag
        logic sent;   // flag carried by the request in flight
    } spec_regs_t;

endpackage

// File: rtl/fetch_spec_track.sv
module fetch_spec_track
    import fsc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flush_i,
    input  logic resolve_i,
    input  logic issue_i,
    input  logic take_branch_i,
    input  logic reject_i,
    output logic spec_o
);

    spec_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.spec = r_q.spec & ~resolve_i;
        r_d.sent = r_q.sent & ~resolve_i;
        if (issue_i) begin
            r_d.sent = r_q.spec & ~resolve_i;
        end
        if (reject_i) begin
            // roll back to what the rejected request carried
            r_d.spec = r_q.sent & ~resolve_i;
        end else if (take_branch_i) begin
            r_d.spec = 1'b1;
        end
        if (flush_i) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign spec_o = r_q.spec;

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fsc_pkg::*;
#(
    parameter int unsigned    AW          = 32,
    parameter int unsigned    INSTR_BYTES = 4,
    parameter logic [AW-1:0]  RESET_PC    = 32'h0000_1000
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_pc_i,
    input  logic          blocked_i,
    input  logic          req_ready_i,
    input  logic          rsp_valid_i,
    input  logic          replay_i,
    input  logic          q_ready_i,
    output logic          req_valid_o,
    output logic [AW-1:0] pc_o,
    output logic          issue_o,
    output logic          take_o,
    output logic          stall_o
);

    localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] pc;
    } seq_regs_t;

    seq_regs_t s_q, s_d;
    logic      in_flight;

    always_comb begin
        s_d         = s_q;
        req_valid_o = (s_q.st == ST_REQ) && !blocked_i;
        issue_o     = req_valid_o && req_ready_i;
        take_o      = (s_q.st == ST_WAIT) && rsp_valid_i;
        stall_o     = ((s_q.st == ST_REQ) && blocked_i) || (s_q.st == ST_HOLD);

        unique case (s_q.st)
            ST_REQ: begin
                if (issue_o) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (replay_i) begin
                        s_d.st = ST_HOLD;
                    end else begin
                        s_d.st = ST_REQ;
                        s_d.pc = s_q.pc + STEP;
                    end
                end
            end
            ST_HOLD: begin
                if (q_ready_i) s_d.st = ST_REQ;
            end
            ST_DRAIN: begin
                if (rsp_valid_i) s_d.st = ST_REQ;
            end
            default: s_d.st = ST_REQ;
        endcase

        in_flight = issue_o
                 || (((s_q.st == ST_WAIT) || (s_q.st == ST_DRAIN)) && !rsp_valid_i);
        if (flush_i) begin
            s_d.pc = flush_pc_i;
            s_d.st = in_flight ? ST_DRAIN : ST_REQ;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st <= ST_REQ;
            s_q.pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o = s_q.pc;

endmodule

// File: rtl/fetch_spec_ctrl.sv
module fetch_spec_ctrl
    import fsc_pkg::*;
#(
    parameter int unsigned    AW          = 32,
    parameter int unsigned    INSTR_BYTES = 4,
    parameter logic [AW-1:0]  RESET_PC    = 32'h0000_1000
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_pc_i,
    input  logic          region_idem_i,
    output logic          req_valid_o,
    input  logic          req_ready_i,
    output logic [AW-1:0] req_addr_o,
    output logic          req_spec_o,
    input  logic          rsp_valid_i,
    input  logic          rsp_branch_i,
    input  logic          resolve_i,
    input  logic          q_ready_i,
    input  logic          replay_i,
    output logic          stall_o
);

    logic spec_q;
    logic blocked;
    logic issue;
    logic rsp_take;
    logic take_branch;
    logic reject;

    assign blocked     = spec_q && !region_idem_i;
    assign take_branch = rsp_take && rsp_branch_i && !replay_i;
    assign reject      = rsp_take && replay_i;

    fetch_seq #(
        .AW          (AW),
        .INSTR_BYTES (INSTR_BYTES),
        .RESET_PC    (RESET_PC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush_i),
        .flush_pc_i  (flush_pc_i),
        .blocked_i   (blocked),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .replay_i    (replay_i),
        .q_ready_i   (q_ready_i),
        .req_valid_o (req_valid_o),
        .pc_o        (req_addr_o),
        .issue_o     (issue),
        .take_o      (rsp_take),
        .stall_o     (stall_o)
    );

    fetch_spec_track u_track (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .flush_i       (flush_i),
        .resolve_i     (resolve_i),
        .issue_i       (issue),
        .take_branch_i (take_branch),
        .reject_i      (reject),
        .spec_o        (spec_q)
    );

    assign req_spec_o = spec_q;

endmodule

// File: rtl/fetch_spec_ctrl_chk.sv
module fetch_spec_ctrl_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          flush_i,
    input logic          resolve_i,
    input logic          replay_i,
    input logic          rsp_branch_i,
    input logic          region_idem_i,
    input logic          req_valid_o,
    input logic          req_ready_i,
    input logic [AW-1:0] req_addr_o,
    input logic          req_spec_o,
    input logic          stall_o,
    input logic          rsp_take
);

    a_r4_no_spec_nonidem: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (!req_spec_o || region_idem_i));

    a_r9_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !req_ready_i && !flush_i && !resolve_i)
        |=> ($stable(req_addr_o) && $stable(req_spec_o)));

    a_r10_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !req_spec_o);

    a_r6_branch_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_take && rsp_branch_i && !replay_i && !flush_i) |=> req_spec_o);

    a_r6_resolve_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resolve_i && !(rsp_take && rsp_branch_i && !replay_i)) |=> !req_spec_o);

    a_r7_replay_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_take && replay_i && !flush_i) |=> (!req_valid_o && stall_o));

endmodule

bind fetch_spec_ctrl fetch_spec_ctrl_chk #(.AW(AW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .resolve_i     (resolve_i),
    .replay_i      (replay_i),
    .rsp_branch_i  (rsp_branch_i),
    .region_idem_i (region_idem_i),
    .req_valid_o   (req_valid_o),
    .req_ready_i   (req_ready_i),
    .req_addr_o    (req_addr_o),
    .req_spec_o    (req_spec_o),
    .stall_o       (stall_o),
    .rsp_take      (rsp_take)
);

// File: tb/tb_fetch_spec_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_spec_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          flush_i = 1'b0;
    logic [AW-1:0] flush_pc_i = '0;
    logic          region_idem_i = 1'b1;
    logic          req_valid_o;
    logic          req_ready_i = 1'b0;
    logic [AW-1:0] req_addr_o;
    logic          req_spec_o;
    logic          rsp_valid_i = 1'b0;
    logic          rsp_branch_i = 1'b0;
    logic          resolve_i = 1'b0;
    logic          q_ready_i = 1'b1;
    logic          replay_i = 1'b0;
    logic          stall_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit hs_seen = 1'b0;

    logic [AW:0]   exp_q[$];       // {spec, addr}
    logic [AW-1:0] m_pc = 32'h1000;
    logic          m_spec = 1'b0;
    logic          m_sent = 1'b0;

    always #2.5 clk = ~clk;

    fetch_spec_ctrl dut (
        .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .flush_pc_i(flush_pc_i),
        .region_idem_i(region_idem_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_spec_o(req_spec_o), .rsp_valid_i(rsp_valid_i),
        .rsp_branch_i(rsp_branch_i), .resolve_i(resolve_i), .q_ready_i(q_ready_i),
        .replay_i(replay_i), .stall_o(stall_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: sample 1 ns before each rising edge, compare handshakes with scoreboard
    always begin
        @(negedge clk);
        #1.5;
        if (rst_ni && req_valid_o && req_ready_i) begin
            hs_seen = 1'b1;
            if (exp_q.size() == 0) begin
                chk("R2 unexpected request", req_addr_o, '1);
            end else begin
                logic [AW:0] e;
                e = exp_q.pop_front();
                chk("R2 request address", req_addr_o, e[AW-1:0]);
                chk("R3/R5 request spec", {31'd0, req_spec_o}, {31'd0, e[AW]});
            end
        end
    end

    task automatic issue_req(input logic idem);
        int n;
        region_idem_i = idem;
        req_ready_i   = 1'b1;
        exp_q.push_back({m_spec, m_pc});
        m_sent  = m_spec;
        hs_seen = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!hs_seen && n < 20);
        if (!hs_seen) chk("R5 request never issued", 32'd0, 32'd1);
        req_ready_i = 1'b0;
    endtask

    task automatic respond(input logic br, input logic rej, input logic res);
        rsp_valid_i  = 1'b1;
        rsp_branch_i = br;
        replay_i     = rej;
        resolve_i    = res;
        @(negedge clk);
        rsp_valid_i  = 1'b0;
        rsp_branch_i = 1'b0;
        replay_i     = 1'b0;
        resolve_i    = 1'b0;
        if (rej) begin
            m_spec = m_sent & ~res;
        end else begin
            m_spec = br ? 1'b1 : (m_spec & ~res);
            m_pc   = m_pc + 32'd4;
        end
    endtask

    task automatic fetch(input logic idem, input logic br, input logic rej, input logic res);
        issue_req(idem);
        respond(br, rej, res);
    endtask

    task automatic pulse_resolve();
        resolve_i = 1'b1;
        @(negedge clk);
        resolve_i = 1'b0;
        m_spec = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid after reset", {31'd0, req_valid_o}, 32'd1);
        chk("R1 reset address", req_addr_o, 32'h1000);
        chk("R1 spec after reset", {31'd0, req_spec_o}, 32'd0);
        chk("R1 stall after reset", {31'd0, stall_o}, 32'd0);

        // R2 sequential fetches
        fetch(1, 0, 0, 0);
        fetch(1, 0, 0, 0);
        chk("R2 address advanced", req_addr_o, 32'h1008);

        // R3 branch sets spec; R5 idempotent speculative request issues
        fetch(1, 1, 0, 0);
        chk("R3 spec set by branch", {31'd0, req_spec_o}, 32'd1);
        fetch(1, 0, 0, 0);
        chk("R5 idempotent speculative valid", {31'd0, req_valid_o}, 32'd1);

        // R4 blocking for non-idempotent region
        region_idem_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4 no request while speculative", {31'd0, req_valid_o}, 32'd0);
            chk("R4 stall while speculative", {31'd0, stall_o}, 32'd1);
        end
        pulse_resolve();
        chk("R6 resolve clears spec", {31'd0, req_spec_o}, 32'd0);
        chk("R4 released after resolve", {31'd0, req_valid_o}, 32'd1);

        // R6 branch and resolve in the same cycle
        fetch(1, 1, 0, 0);
        fetch(1, 1, 0, 1);
        chk("R6 branch wins over resolve", {31'd0, req_spec_o}, 32'd1);

        // R8 rollback keeps earlier speculation in idempotent region
        fetch(1, 0, 1, 0);
        chk("R7 stall after replay", {31'd0, stall_o}, 32'd1);
        @(negedge clk);
        chk("R8 rollback keeps prior spec", {31'd0, req_spec_o}, 32'd1);
        chk("R7 same address after replay", req_addr_o, m_pc);
        pulse_resolve();

        // R8 deadlock scenario: non-idempotent branch rejected by full queue
        q_ready_i = 1'b0;
        fetch(0, 1, 1, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R7 no request while queue full", {31'd0, req_valid_o}, 32'd0);
            chk("R7 stall while queue full", {31'd0, stall_o}, 32'd1);
            @(negedge clk);
        end
        q_ready_i = 1'b1;
        begin
            int cnt = 0;
            while (!req_valid_o && cnt < 8) begin
                @(negedge clk);
                cnt++;
            end
            chk("R8 refetch within bound", {31'd0, (cnt <= 2)}, 32'd1);
        end
        chk("R8 refetch not speculative", {31'd0, req_spec_o}, 32'd0);
        chk("R7 refetch same address", req_addr_o, m_pc);
        fetch(0, 1, 0, 0);
        chk("R3 spec set after accepted branch", {31'd0, req_spec_o}, 32'd1);
        pulse_resolve();

        // R9 stability while cache not ready
        region_idem_i = 1'b1;
        begin
            logic [AW-1:0] a0;
            a0 = req_addr_o;
            repeat (3) @(negedge clk);
            chk("R9 address stable", req_addr_o, a0);
            chk("R9 valid held", {31'd0, req_valid_o}, 32'd1);
        end

        // R10 flush in request state clears spec
        fetch(1, 1, 0, 0);
        flush_i = 1'b1;
        flush_pc_i = 32'h2000;
        @(negedge clk);
        flush_i = 1'b0;
        m_pc = 32'h2000;
        m_spec = 1'b0;
        chk("R10 flush address", req_addr_o, 32'h2000);
        chk("R10 flush clears spec", {31'd0, req_spec_o}, 32'd0);

        // R10 flush while a response is outstanding
        issue_req(1);
        flush_i = 1'b1;
        flush_pc_i = 32'h3000;
        @(negedge clk);
        flush_i = 1'b0;
        chk("R10 no request while draining", {31'd0, req_valid_o}, 32'd0);
        rsp_valid_i = 1'b1;
        rsp_branch_i = 1'b1;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        rsp_branch_i = 1'b0;
        m_pc = 32'h3000;
        chk("R10 dropped response leaves spec", {31'd0, req_spec_o}, 32'd0);
        chk("R10 address after drain", req_addr_o, 32'h3000);
        fetch(1, 0, 0, 0);
        chk("R2 address after redirect", req_addr_o, 32'h3004);
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule